// File: doc/BRIEF.md
# Seconds Counter with Programmable Alarm

This block keeps wall-clock time as a 32-bit count of seconds on a small memory-mapped register bus. A prescaler divides the system clock by `CLK_HZ` to make a one-second tick, and the seconds count steps by one on each tick. Software can overwrite the running count, program an alarm value, and mask, inspect and clear a level interrupt. The interrupt is raised when the count equals the alarm value.

The alarm compare is made against the value the count and alarm registers are about to take. A tick that lands on the alarm value therefore flags the interrupt on the same edge as the increment. Rewriting either operand so that the two agree flags it at once. Reads are combinational from the register state. A write takes effect on the clock edge where `bus_valid` and `bus_write` are both high. A read window of 4 KiB also holds eight identification bytes, one per 32-bit word.

Top module: `rtcs_top`

## Requirements
- R1: Synchronous reset clears the seconds count, the alarm value, the mask bit, the raw status and the prescaler, and holds `irq` low.
- R2: The count increments by one every `CLK_HZ` clock cycles. The first increment falls on the `CLK_HZ`-th rising edge after reset is released.
- R3: A write to offset 0x08 sets the count to the written value on that edge, in place of any tick on the same edge. A read of 0x00 returns the count, and a read of 0x08 returns the last value written there.
- R4: A write to offset 0x04 stores the alarm value, and a read of 0x04 returns it.
- R5: When a tick brings the count to the alarm value, raw status (bit 0 of offset 0x14) is set on the same edge as the increment. This includes the step from 0xFFFFFFFF to 0.
- R6: A write to 0x08 whose value equals the stored alarm value sets raw status on that edge.
- R7: A write to 0x04 whose value equals the current count sets raw status on that edge. A write that does not match leaves raw status clear.
- R8: Raw status stays set until offset 0x1C is written, and a write of any value clears it. If a new alarm hit falls on the same edge as the clear, raw status stays set.
- R9: Only bit 0 of the mask register (0x10) is implemented. Masked status (0x18) is raw status AND mask, and `irq` equals masked status.
- R10: Offset 0x0C reads as 1, and writes to it have no effect.
- R11: Word offsets 0xFE0 to 0xFFC read the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R12: Writes to 0x00, 0x14 and 0x18 are ignored. Reads of 0x1C and of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| irq | output | 1 | Level interrupt, equal to masked status |

## Verification
The bench aims a count load at the exact edge where a tick falls. A design that let the tick win would read back the loaded value plus one. It walks the count across the 32-bit wrap onto an alarm value of zero. A compare that used the old count, or wrapped wrongly, would flag the alarm a cycle late or not at all. It writes the clear register with data 0, which a design that tested a data bit would ignore. It also lines a clear write up with an alarm hit, so that a design giving the clear priority would lose the event. Finally, it writes alarm and load values equal to the other operand, which a design that compared only on ticks would miss until the next second.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int WIDX_W = ADDR_W - 2;

    // Word indices of the mapped registers (byte offset >> 2)
    localparam logic [WIDX_W-1:0] WI_COUNT  = 10'h000;
    localparam logic [WIDX_W-1:0] WI_MATCH  = 10'h001;
    localparam logic [WIDX_W-1:0] WI_LOAD   = 10'h002;
    localparam logic [WIDX_W-1:0] WI_CTRL   = 10'h003;
    localparam logic [WIDX_W-1:0] WI_MASK   = 10'h004;
    localparam logic [WIDX_W-1:0] WI_RAW    = 10'h005;
    localparam logic [WIDX_W-1:0] WI_MASKED = 10'h006;
    localparam logic [WIDX_W-1:0] WI_CLEAR  = 10'h007;

    typedef enum logic [3:0] {
        SEL_COUNT,
        SEL_MATCH,
        SEL_LOAD,
        SEL_CTRL,
        SEL_MASK,
        SEL_RAW,
        SEL_MASKED,
        SEL_CLEAR,
        SEL_IDENT,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              load_we;
        logic              match_we;
        logic              mask_we;
        logic              clear_we;
        logic [DATA_W-1:0] wdata;
    } wr_cmd_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a[ADDR_W-1:5] == '1) begin
            s = SEL_IDENT;
        end else begin
            case (a[ADDR_W-1:2])
                WI_COUNT:  s = SEL_COUNT;
                WI_MATCH:  s = SEL_MATCH;
                WI_LOAD:   s = SEL_LOAD;
                WI_CTRL:   s = SEL_CTRL;
                WI_MASK:   s = SEL_MASK;
                WI_RAW:    s = SEL_RAW;
                WI_MASKED: s = SEL_MASKED;
                WI_CLEAR:  s = SEL_CLEAR;
                default:   s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    // Identification bytes, one per word in the top 32 bytes of the window
    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h31;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h14;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rtcs_prescaler.sv
module rtcs_prescaler #(
    parameter int CLK_HZ = 32768
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;

    generate
        if (CLK_HZ <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam logic [PW-1:0] LAST = PW'(CLK_HZ - 1);
            logic [PW-1:0] pcnt_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    pcnt_q <= '0;
                end else if (pcnt_q == LAST) begin
                    pcnt_q <= '0;
                end else begin
                    pcnt_q <= pcnt_q + 1'b1;
                end
            end

            assign tick = (pcnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/rtcs_counter.sv
module rtcs_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next,
    output logic             cnt_evt
);
    // A load overrides a tick on the same edge
    always_comb begin
        if (load_we) begin
            cnt_next = load_val;
        end else if (tick) begin
            cnt_next = cnt_q + 1'b1;
        end else begin
            cnt_next = cnt_q;
        end
    end

    assign cnt_evt = load_we | tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_next;
        end
    end

endmodule

// File: rtl/rtcs_alarm.sv
module rtcs_alarm #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             cnt_evt,
    input  logic             match_we,
    input  logic [CNT_W-1:0] match_val,
    input  logic             mask_we,
    input  logic             mask_val,
    input  logic             clear_we,
    output logic [CNT_W-1:0] match_q,
    output logic             mask_q,
    output logic             raw_q
);
    logic [CNT_W-1:0] match_next;
    logic             hit;

    assign match_next = match_we ? match_val : match_q;

    // Compare on the values about to be registered; evaluate only on change
    assign hit = (cnt_evt | match_we) && (cnt_next == match_next);

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            mask_q  <= 1'b0;
            raw_q   <= 1'b0;
        end else begin
            match_q <= match_next;
            if (mask_we) begin
                mask_q <= mask_val;
            end
            if (hit) begin
                raw_q <= 1'b1;
            end else if (clear_we) begin
                raw_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rtcs_regif.sv
module rtcs_regif
    import rtcs_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output wr_cmd_t           cmd,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [CNT_W-1:0]  match_q,
    input  logic              mask_q,
    input  logic              raw_q
);
    reg_sel_e          sel;
    logic              wr_go;
    logic              rd_go;
    logic [DATA_W-1:0] load_shadow_q;

    assign sel   = decode_addr(bus_addr);
    assign wr_go = bus_valid & bus_write;
    assign rd_go = bus_valid & ~bus_write;

    always_comb begin
        cmd          = '0;
        cmd.wdata    = bus_wdata;
        cmd.load_we  = wr_go && (sel == SEL_LOAD);
        cmd.match_we = wr_go && (sel == SEL_MATCH);
        cmd.mask_we  = wr_go && (sel == SEL_MASK);
        cmd.clear_we = wr_go && (sel == SEL_CLEAR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_shadow_q <= '0;
        end else if (cmd.load_we) begin
            load_shadow_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_go) begin
            case (sel)
                SEL_COUNT:  bus_rdata = DATA_W'(cnt_q);
                SEL_MATCH:  bus_rdata = DATA_W'(match_q);
                SEL_LOAD:   bus_rdata = load_shadow_q;
                SEL_CTRL:   bus_rdata = DATA_W'(1);
                SEL_MASK:   bus_rdata = DATA_W'(mask_q);
                SEL_RAW:    bus_rdata = DATA_W'(raw_q);
                SEL_MASKED: bus_rdata = DATA_W'(raw_q & mask_q);
                SEL_IDENT:  bus_rdata = DATA_W'(ident_byte(bus_addr[4:2]));
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rtcs_top.sv
module rtcs_top
    import rtcs_pkg::*;
#(
    parameter int CLK_HZ = 32768,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    wr_cmd_t          cmd;
    logic             tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             cnt_evt;
    logic [CNT_W-1:0] match_q;
    logic             mask_q;
    logic             raw_q;

    rtcs_prescaler #(.CLK_HZ(CLK_HZ)) presc_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rtcs_regif #(.CNT_W(CNT_W)) regif_i (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cmd       (cmd),
        .cnt_q     (cnt_q),
        .match_q   (match_q),
        .mask_q    (mask_q),
        .raw_q     (raw_q)
    );

    rtcs_counter #(.CNT_W(CNT_W)) counter_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load_we  (cmd.load_we),
        .load_val (cmd.wdata[CNT_W-1:0]),
        .cnt_q    (cnt_q),
        .cnt_next (cnt_next),
        .cnt_evt  (cnt_evt)
    );

    rtcs_alarm #(.CNT_W(CNT_W)) alarm_i (
        .clk       (clk),
        .rst       (rst),
        .cnt_next  (cnt_next),
        .cnt_evt   (cnt_evt),
        .match_we  (cmd.match_we),
        .match_val (cmd.wdata[CNT_W-1:0]),
        .mask_we   (cmd.mask_we),
        .mask_val  (cmd.wdata[0]),
        .clear_we  (cmd.clear_we),
        .match_q   (match_q),
        .mask_q    (mask_q),
        .raw_q     (raw_q)
    );

    assign irq = raw_q & mask_q;

endmodule

// File: rtl/rtcs_chk.sv
module rtcs_chk
    import rtcs_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              tick,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  match_q,
    input logic              mask_q,
    input logic              raw_q
);
    logic load_wr;
    logic match_wr;
    logic clear_wr;
    logic ctrl_rd;

    assign load_wr  = bus_valid && bus_write && (decode_addr(bus_addr) == SEL_LOAD);
    assign match_wr = bus_valid && bus_write && (decode_addr(bus_addr) == SEL_MATCH);
    assign clear_wr = bus_valid && bus_write && (decode_addr(bus_addr) == SEL_CLEAR);
    assign ctrl_rd  = bus_valid && !bus_write && (decode_addr(bus_addr) == SEL_CTRL);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && match_q == '0 && !raw_q && !mask_q && !irq));

    a_r2_count_steps: assert property (@(posedge clk) disable iff (rst)
        !load_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

    a_r3_load_takes: assert property (@(posedge clk) disable iff (rst)
        load_wr |=> (cnt_q == $past(bus_wdata[CNT_W-1:0])));

    a_r4_match_stores: assert property (@(posedge clk) disable iff (rst)
        match_wr |=> (match_q == $past(bus_wdata[CNT_W-1:0])));

    a_r5_tick_hit: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_wr && !match_wr && (CNT_W'(cnt_q + 1'b1) == match_q)) |=> raw_q);

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (raw_q && !clear_wr) |=> raw_q);

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> mask_q);

    a_r10_ctrl_one: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd |-> (bus_rdata == DATA_W'(1)));

endmodule

bind rtcs_top rtcs_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .tick      (tick),
    .cnt_q     (cnt_q),
    .match_q   (match_q),
    .mask_q    (mask_q),
    .raw_q     (raw_q)
);

// File: tb/rtcs_top_tb_top.sv
module rtcs_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 64;
    localparam int NV         = 31;

    localparam logic [11:0] A_CNT = 12'h000, A_MAT = 12'h004, A_LD  = 12'h008;
    localparam logic [11:0] A_CTL = 12'h00C, A_MSK = 12'h010, A_RAW = 12'h014;
    localparam logic [11:0] A_MIS = 12'h018, A_CLR = 12'h01C;

    typedef struct packed {
        logic        rd;
        logic [11:0] addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    // rd=1: read and compare with data; rd=0: write data
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h008, 32'h1234_5678, 8'd3},   // R3 load
        '{1'b1, 12'h000, 32'h1234_5678, 8'd3},   // R3 count reads loaded value
        '{1'b1, 12'h008, 32'h1234_5678, 8'd3},   // R3 load readback
        '{1'b0, 12'h004, 32'hCAFE_0000, 8'd4},   // R4 match write
        '{1'b1, 12'h004, 32'hCAFE_0000, 8'd4},   // R4 match readback
        '{1'b1, 12'h014, 32'h0,         8'd7},   // R7 no match -> raw clear
        '{1'b0, 12'h00C, 32'h0,         8'd10},  // R10 write ignored
        '{1'b1, 12'h00C, 32'h1,         8'd10},  // R10 reads 1
        '{1'b0, 12'h000, 32'h0,         8'd12},  // R12 write to count ignored
        '{1'b1, 12'h000, 32'h1234_5678, 8'd12},
        '{1'b0, 12'h014, 32'h1,         8'd12},  // R12 write to raw ignored
        '{1'b1, 12'h014, 32'h0,         8'd12},
        '{1'b0, 12'h018, 32'h1,         8'd12},  // R12 write to masked ignored
        '{1'b1, 12'h018, 32'h0,         8'd12},
        '{1'b0, 12'h010, 32'hFFFF_FFFF, 8'd9},   // R9 only bit 0 kept
        '{1'b1, 12'h010, 32'h1,         8'd9},
        '{1'b1, 12'h018, 32'h0,         8'd9},
        '{1'b0, 12'h010, 32'h0,         8'd9},
        '{1'b1, 12'h010, 32'h0,         8'd9},
        '{1'b1, 12'h01C, 32'h0,         8'd12},  // R12 clear reads 0
        '{1'b1, 12'h020, 32'h0,         8'd12},  // R12 unmapped
        '{1'b1, 12'hFDC, 32'h0,         8'd12},
        '{1'b1, 12'hFE0, 32'h31,        8'd11},  // R11 identification
        '{1'b1, 12'hFE4, 32'h10,        8'd11},
        '{1'b1, 12'hFE8, 32'h14,        8'd11},
        '{1'b1, 12'hFEC, 32'h00,        8'd11},
        '{1'b1, 12'hFF0, 32'h0D,        8'd11},
        '{1'b1, 12'hFF4, 32'hF0,        8'd11},
        '{1'b1, 12'hFF8, 32'h05,        8'd11},
        '{1'b1, 12'hFFC, 32'hB1,        8'd11},
        '{1'b1, 12'h800, 32'h0,         8'd12}   // R12 unmapped
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtcs_top #(.CLK_HZ(DIV)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    // Return just after the edge on which the count changed
    task automatic sync_tick();
        logic [31:0] prev;
        logic [31:0] cur;
        logic        seen;
        seen = 1'b0;
        bus_rd(A_CNT, prev);
        for (int i = 0; i < DIV + 4 && !seen; i++) begin
            step();
            bus_rd(A_CNT, cur);
            if (cur != prev) seen = 1'b1;
        end
        check("R2 tick seen within period", {31'd0, seen}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] c;
        logic        hit0;

        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        bus_rd(A_CNT, v); check("R1 count", v, 0);
        bus_rd(A_MAT, v); check("R1 match", v, 0);
        bus_rd(A_MSK, v); check("R1 mask", v, 0);
        bus_rd(A_RAW, v); check("R1 raw", v, 0);
        check("R1 irq", {31'd0, irq}, 0);
        rst = 1'b0;

        // R2 first increment on the DIV-th edge
        repeat (DIV - 1) @(posedge clk);
        @(negedge clk);
        bus_rd(A_CNT, v); check("R2 count before first tick", v, 0);
        step();
        bus_rd(A_CNT, v); check("R2 count after first tick", v, 1);

        // Vector table
        sync_tick();
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                bus_rd(VECS[i].addr, v);
                check($sformatf("R%0d table entry %0d", VECS[i].req, i), v, VECS[i].data);
                step();
            end else begin
                bus_wr(VECS[i].addr, VECS[i].data);
            end
        end

        // R6 load equal to alarm value
        sync_tick();
        bus_wr(A_MSK, 32'h1);
        bus_wr(A_MAT, 32'h100);
        bus_rd(A_RAW, v); check("R7 non-matching alarm write", v, 0);
        bus_wr(A_LD, 32'h100);
        bus_rd(A_RAW, v); check("R6 load hits alarm", v, 1);
        check("R9 irq follows masked", {31'd0, irq}, 1);
        bus_rd(A_MIS, v); check("R9 masked status", v, 1);
        bus_wr(A_MSK, 32'h0);
        check("R9 irq masked off", {31'd0, irq}, 0);
        bus_rd(A_RAW, v); check("R9 raw kept while masked", v, 1);
        // R8 sticky, cleared by any value
        step(); step();
        bus_rd(A_RAW, v); check("R8 raw sticky", v, 1);
        bus_wr(A_CLR, 32'h0);
        bus_rd(A_RAW, v); check("R8 clear with data 0", v, 0);

        // R7 alarm write equal to count
        sync_tick();
        bus_wr(A_LD, 32'h500);
        bus_wr(A_MAT, 32'h500);
        bus_rd(A_RAW, v); check("R7 alarm write hits count", v, 1);
        bus_wr(A_CLR, 32'hDEAD_BEEF);
        bus_rd(A_RAW, v); check("R8 clear with arbitrary data", v, 0);

        // R3 load on the tick edge wins
        sync_tick();
        repeat (DIV - 1) @(posedge clk);
        @(negedge clk);
        bus_wr(A_LD, 32'h77);
        bus_rd(A_CNT, v); check("R3 load beats tick", v, 32'h77);

        // R8 hit on the same edge as a clear keeps raw set
        sync_tick();
        bus_wr(A_CLR, 32'h0);
        bus_rd(A_CNT, c);
        bus_wr(A_MAT, c + 1);
        bus_rd(A_RAW, v); check("R8 raw clear before hit", v, 0);
        repeat (DIV - 3) @(posedge clk);
        @(negedge clk);
        bus_wr(A_CLR, 32'h1);
        bus_rd(A_CNT, v); check("R5 count reached alarm", v, c + 1);
        bus_rd(A_RAW, v); check("R8 hit beats clear", v, 1);
        bus_wr(A_CLR, 32'h1);

        // R5 wrap from all ones to zero onto alarm 0
        sync_tick();
        bus_wr(A_MSK, 32'h1);
        bus_wr(A_LD, 32'hFFFF_FFFF);
        bus_wr(A_MAT, 32'h0);
        bus_rd(A_RAW, v); check("R5 no early hit before wrap", v, 0);
        hit0 = 1'b0;
        for (int i = 0; i < DIV + 4 && !hit0; i++) begin
            step();
            bus_rd(A_CNT, v);
            if (v == 0) begin
                hit0 = 1'b1;
                bus_rd(A_RAW, v); check("R5 raw set with wrap increment", v, 1);
                check("R5 irq at wrap", {31'd0, irq}, 1);
            end
        end
        check("R5 count wrapped", {31'd0, hit0}, 1);

        // R1 reset in mid-run
        rst = 1'b1;
        step();
        rst = 1'b0;
        bus_rd(A_CNT, v); check("R1 count after reset", v, 0);
        bus_rd(A_MAT, v); check("R1 match after reset", v, 0);
        bus_rd(A_RAW, v); check("R1 raw after reset", v, 0);
        check("R1 irq after reset", {31'd0, irq}, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule